// File: doc/BRIEF.md
# Gated Fault Capture Latch

This block keeps a sticky record of which monitored inputs have faulted, so that software can find out later what went wrong. Each input owns one latch bit. While the current sequencer state allows capture, a fault on an input sets its bit. The bit stays set after the fault goes away and is cleared only by an explicit clear command. When the sequencer moves through a state where trips are expected, such as a controlled power-down, that state holds capture off and nothing is logged.

The latched bits are packed into byte-wide registers. Register 0 holds inputs 0 to 7 and register 1 holds inputs 8 to 15. Bit j of register s holds input 8*s+j, and positions with no input behind them read as 0. A management agent reads a register through a valid/ready request channel that carries the register select. The byte comes back on a valid/ready response channel that holds one entry.

Back-pressure rules:
- A request is accepted when `req_valid` and `req_ready` are both high at a rising edge.
- `req_ready` is high when the response slot is empty or is being drained in the same cycle.
- A response stays valid, with its data unchanged, until `rsp_ready` takes it.

A summary output reports whether any bit is latched.

Top module: `flt_capture_latch`

## Requirements
- R1: After reset every latched bit is 0, `any_fault` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: When `capture_en` is 1 at a rising edge, each input with `fault_in` high has its bit set from the next cycle. Bit j of register s holds input 8*s+j.
- R3: A latched bit stays set after its fault input returns low, as long as no clear occurs.
- R4: When `capture_en` is 0 and `clr` is 0, the latched bits keep their value whatever `fault_in` does.
- R5: `clr` high at a rising edge zeroes every latched bit whose input is not being captured in that same cycle.
- R6: A fault captured in the same cycle as `clr` wins: its bit is set after the edge.
- R7: `any_fault` is 1 exactly when at least one latched bit is 1.
- R8: A request accepted at an edge yields `rsp_valid` high in the next cycle. Its `rsp_data` is the selected register (`req_sel` 0 holds inputs 0 to 7, 1 holds inputs 8 to 15) as it stood just before that edge.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1, `rsp_data` stays stable and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | 16 | Per-input fault indications |
| capture_en | input | 1 | Capture allowed in the current sequencer state |
| clr | input | 1 | Clear all latched bits |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted this cycle if valid |
| req_sel | input | 1 | Register select |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer accepts read data |
| rsp_data | output | 8 | Selected register contents |
| any_fault | output | 1 | OR of all latched bits |

## Verification
A wrong latch bit shows at the ports as a mismatch in the byte returned by the next read of its register. It also shows as a wrong `any_fault` in the cycle after the bad edge. The bench therefore keeps its own latch model and reads both registers after every scenario. It compares `any_fault` on each checked cycle. A fault in the response slot shows as a lost, duplicated or changed byte while back-pressure is applied. The scoreboard detects this the moment the transfer completes.

// File: rtl/flt_pkg.sv
package flt_pkg;
  parameter int unsigned DEF_REG_W = 8;

  function automatic int unsigned sel_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/flt_capture_bank.sv
module flt_capture_bank #(
  parameter int unsigned NUM_INPUTS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] fault_in,
  input  logic                  capture_en,
  input  logic                  clr,
  output logic [NUM_INPUTS-1:0] latched
);
  logic [NUM_INPUTS-1:0] captured;

  assign captured = capture_en ? fault_in : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)   latched <= '0;
    else if (clr) latched <= captured;
    else          latched <= latched | captured;
  end

  // R2: captured faults are present after the edge
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> ((latched & $past(fault_in)) == $past(fault_in)));

  // R3: no bit drops without a clear
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((latched & $past(latched)) == $past(latched)));

  // R4: gated state holds
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !clr) |=> (latched == $past(latched)));

  // R5: clear without capture empties the latch
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !capture_en) |=> (latched == '0));
endmodule

// File: rtl/flt_read_port.sv
module flt_read_port #(
  parameter int unsigned NUM_INPUTS = 16,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned NUM_REGS   = 2,
  parameter int unsigned SEL_W      = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] latched,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [SEL_W-1:0]      req_sel,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [REG_W-1:0]      rsp_data
);
  logic [NUM_REGS-1:0][REG_W-1:0] view;
  logic [REG_W-1:0]               sel_data;
  logic                           req_fire;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (r * REG_W + b < NUM_INPUTS) begin : g_used
        assign view[r][b] = latched[r*REG_W+b];
      end else begin : g_pad
        assign view[r][b] = 1'b0;
      end
    end
  end

  always_comb begin
    sel_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (req_sel == SEL_W'(r)) sel_data = view[r];
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: an accepted request produces a response
  p_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: stalled response is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/flt_capture_latch.sv
module flt_capture_latch
  import flt_pkg::*;
#(
  parameter int unsigned NUM_INPUTS = 16,
  parameter int unsigned REG_W      = DEF_REG_W,
  localparam int unsigned NUM_REGS  = (NUM_INPUTS + REG_W - 1) / REG_W,
  localparam int unsigned SEL_W     = sel_bits(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] fault_in,
  input  logic                  capture_en,
  input  logic                  clr,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [SEL_W-1:0]      req_sel,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [REG_W-1:0]      rsp_data,
  output logic                  any_fault
);
  logic [NUM_INPUTS-1:0] latched;

  flt_capture_bank #(.NUM_INPUTS(NUM_INPUTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
    .capture_en(capture_en), .clr(clr), .latched(latched)
  );

  flt_read_port #(
    .NUM_INPUTS(NUM_INPUTS), .REG_W(REG_W),
    .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) u_read (
    .clk(clk), .rst_n(rst_n), .latched(latched),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  assign any_fault = |latched;

  // R6: a fault captured during a clear survives it
  p_clr_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && capture_en && (fault_in != '0)) |=> any_fault);

  // R7: summary falls after a clear with nothing captured
  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (!capture_en || (fault_in == '0))) |=> !any_fault);
endmodule

// File: tb/flt_capture_latch_tb.sv
module flt_capture_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fault_in = '0;
  logic        capture_en = 1'b0;
  logic        clr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [0:0]  req_sel = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        any_fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_lat = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  flt_capture_latch u_dut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .capture_en(capture_en),
    .clr(clr), .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .any_fault(any_fault)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slice(logic sel);
    return sel ? exp_lat[15:8] : exp_lat[7:0];
  endfunction

  task automatic cycle(string tag);
    logic [15:0] capf;
    logic [15:0] nxt;
    #1;
    if (req_valid && req_ready) begin
      exp_q.push_back(slice(req_sel));
      tag_q.push_back(tag);
    end
    capf = capture_en ? fault_in : 16'h0;
    nxt  = clr ? capf : (exp_lat | capf);
    @(posedge clk);
    @(negedge clk);
    exp_lat = nxt;
  endtask

  task automatic do_read(logic sel, string tag);
    req_valid = 1'b1;
    req_sel   = sel;
    cycle(tag);
    req_valid = 1'b0;
  endtask

  task automatic read_both(string tag);
    do_read(1'b0, tag);
    do_read(1'b1, tag);
    cycle(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          fails++;
          $display("FAIL %s read actual=%h expected=%h", t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 any_fault", 16'(any_fault), 16'h0);
    check("R1 rsp_valid", 16'(rsp_valid), 16'h0);
    check("R1 req_ready", 16'(req_ready), 16'h1);
    @(negedge clk);
    read_both("R1");

    // R2, R3: capture inputs 3 and 12, then remove the faults
    capture_en = 1'b1;
    fault_in = 16'h1008;
    cycle("R2");
    fault_in = 16'h0;
    cycle("R3");
    #1;
    check("R7 any_fault set", 16'(any_fault), 16'h1);
    @(negedge clk);
    read_both("R3");

    // R4: capture disabled, every input faulting
    capture_en = 1'b0;
    fault_in = 16'hFFFF;
    cycle("R4");
    cycle("R4");
    read_both("R4");
    fault_in = 16'h0;

    // R2: bit 15 and bit 0 boundaries
    capture_en = 1'b1;
    fault_in = 16'h8001;
    cycle("R2");
    fault_in = 16'h0;
    read_both("R2");

    // R5: clear with capture disabled
    capture_en = 1'b0;
    fault_in = 16'h00F0;
    clr = 1'b1;
    cycle("R5");
    clr = 1'b0;
    fault_in = 16'h0;
    #1;
    check("R5 any_fault cleared", 16'(any_fault), 16'h0);
    check("R7 any_fault clear", 16'(any_fault), 16'(|exp_lat));
    @(negedge clk);
    read_both("R5");

    // R6: set some bits, then clear while input 9 faults
    capture_en = 1'b1;
    fault_in = 16'h0081;
    cycle("R6");
    fault_in = 16'h0200;
    clr = 1'b1;
    cycle("R6");
    clr = 1'b0;
    fault_in = 16'h0;
    #1;
    check("R6 any_fault", 16'(any_fault), 16'h1);
    @(negedge clk);
    read_both("R6");

    // R8: back-to-back reads while a fault lands between them
    req_valid = 1'b1;
    req_sel = 1'b0;
    cycle("R8");
    fault_in = 16'h0402;
    req_sel = 1'b1;
    cycle("R8");
    fault_in = 16'h0;
    req_sel = 1'b0;
    cycle("R8");
    req_valid = 1'b0;
    cycle("R8");

    // R9: back-pressure on the response
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_sel = 1'b1;
    cycle("R9");
    req_valid = 1'b0;
    begin
      logic [7:0] held;
      #1;
      held = rsp_data;
      check("R9 valid under stall", 16'(rsp_valid), 16'h1);
      check("R9 ready low", 16'(req_ready), 16'h0);
      @(negedge clk);
      req_valid = 1'b1;
      req_sel = 1'b0;
      cycle("R9");
      cycle("R9");
      #1;
      check("R9 data held", 16'(rsp_data), 16'(held));
      check("R9 still valid", 16'(rsp_valid), 16'h1);
      check("R9 no accept", 16'(req_ready), 16'h0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    rsp_ready = 1'b1;
    cycle("R9");
    cycle("R9");
    cycle("R9");

    check("R8 queue drained", 16'(exp_q.size()), 16'h0);
    check("R7 final summary", 16'(any_fault), 16'(|exp_lat));
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule